// File: doc/BRIEF.md
# Packed Byte Permute and Align Unit

This unit moves bytes within a 128-bit word. It offers two operations, selected by a one-bit opcode. The align operation joins two operands into one double-width value and slides a window of whole bytes across it. The shuffle operation builds each output byte either from a byte of the first operand, chosen by an index, or as zero. A narrow mode limits both operations to the low 64 bits of the operands.

Each accepted request (input valid high) produces a registered result with a valid flag one clock later. The result register keeps its value while no request arrives. A synchronous active-high reset clears both the flag and the result. Arithmetic, sign and absolute-value work are not part of this unit.

Top module: `byte_perm_unit`

## Requirements
- R1: Align (opSel = 0), wide mode (narrowMode = 0): the result is the low 16 bytes of the 32-byte value {srcHi, srcLo} (srcHi upper) shifted right by imm whole bytes, for imm below 32. With imm = 0 the result is srcLo, and with imm = 16 it is srcHi.
- R2: Align with imm of at least twice the active width in bytes (32 wide, 16 narrow) gives an all-zero result. Counts between one and two widths move srcHi bytes down, with zeros filling from the top.
- R3: Shuffle (opSel = 1), wide mode: when bit 7 of control byte i (byte i of srcLo) is 0, output byte i is the srcHi byte indexed by bits [3:0] of that control byte.
- R4: Shuffle: when bit 7 of a control byte is 1, the matching output byte is zero.
- R5: Shuffle: bits [6:4] of a control byte have no effect on the result.
- R6: Narrow mode (narrowMode = 1): only the low 8 bytes of each operand are used, the active width is 8 bytes, and result bits [127:64] are zero for both operations.
- R7: Narrow shuffle: only bits [2:0] of a control byte index the source, so bit 3 has no effect.
- R8: outValid equals inValid delayed by one clock. The result is loaded only when inValid is high and holds otherwise.
- R9: While the synchronous active-high reset rst is high, outValid and result are cleared at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| opSel | input | 1 | 0 = align, 1 = shuffle |
| narrowMode | input | 1 | 1 = 64-bit operation |
| imm | input | 8 | Align byte count |
| srcHi | input | 128 | First operand (upper half for align, data for shuffle) |
| srcLo | input | 128 | Second operand (lower half for align, controls for shuffle) |
| outValid | output | 1 | Result valid, one clock after inValid |
| result | output | 128 | Registered result |

## Verification
Every result is due exactly one rising edge after the request. The bench drives each request on a falling edge and reads result and outValid on the next falling edge, which is half a cycle after the capturing edge. Hold behaviour is checked one cycle later, after idle cycles with changed operands. Reset clearing is checked on the falling edge that follows a reset edge.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic {
    OP_ALIGN   = 1'b0,
    OP_SHUFFLE = 1'b1
  } bpuOp_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;
    logic selAlign;
    logic narrow;
  } bpuStrobe_t;
endpackage

// File: rtl/bpu_ctrl.sv
module bpu_ctrl
  import bpu_pkg::*;
(
  input  logic       inValid,
  input  logic       opSel,
  input  logic       narrowMode,
  output bpuStrobe_t strobes
);
  bpuOp_e op;

  always_comb begin
    op               = bpuOp_e'(opSel);
    strobes.capture  = inValid;
    strobes.selAlign = (op == OP_ALIGN);
    strobes.narrow   = narrowMode;
  end
endmodule

// File: rtl/bpu_datapath.sv
module bpu_datapath
  import bpu_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bpuStrobe_t                strobes,
  input  logic [LANES*BYTE_W-1:0]   srcHi,
  input  logic [LANES*BYTE_W-1:0]   srcLo,
  input  logic [IMM_W-1:0]          imm,
  output logic                      outValid,
  output logic [LANES*BYTE_W-1:0]   result
);
  localparam int DATA_W = LANES * BYTE_W;
  localparam int HALF   = LANES / 2;
  localparam int IDX_W  = $clog2(LANES);
  localparam int CNT_W  = IMM_W + 2;

  logic [BYTE_W-1:0] hiB   [LANES];
  logic [BYTE_W-1:0] loB   [LANES];
  logic [BYTE_W-1:0] nextB [LANES];
  logic [DATA_W-1:0] nextResult;
  logic [CNT_W-1:0]  span;
  logic [IDX_W-1:0]  idxMask;

  assign span    = strobes.narrow ? CNT_W'(HALF) : CNT_W'(LANES);
  assign idxMask = strobes.narrow ? IDX_W'(HALF - 1) : IDX_W'(LANES - 1);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [CNT_W-1:0]  pos;
    logic [CNT_W-1:0]  hiPos;
    logic [BYTE_W-1:0] alignByte;
    logic [BYTE_W-1:0] shufByte;
    logic [BYTE_W-1:0] ctrlByte;
    logic [IDX_W-1:0]  pick;
    logic              laneOff;

    assign hiB[g] = srcHi[g*BYTE_W +: BYTE_W];
    assign loB[g] = srcLo[g*BYTE_W +: BYTE_W];

    always_comb begin
      laneOff  = (CNT_W'(g) >= span);
      pos      = CNT_W'(g) + CNT_W'(imm);
      hiPos    = pos - span;
      ctrlByte = loB[g];
      pick     = ctrlByte[IDX_W-1:0] & idxMask;

      if (laneOff)                alignByte = '0;
      else if (pos < span)        alignByte = loB[pos[IDX_W-1:0]];
      else if (pos < (span << 1)) alignByte = hiB[hiPos[IDX_W-1:0]];
      else                        alignByte = '0;

      if (laneOff || ctrlByte[BYTE_W-1]) shufByte = '0;
      else                               shufByte = hiB[pick];

      nextB[g] = strobes.selAlign ? alignByte : shufByte;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) nextResult[i*BYTE_W +: BYTE_W] = nextB[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) result <= nextResult;
    end
  end
endmodule

// File: rtl/byte_perm_unit.sv
module byte_perm_unit
  import bpu_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic                    opSel,
  input  logic                    narrowMode,
  input  logic [IMM_W-1:0]        imm,
  input  logic [LANES*BYTE_W-1:0] srcHi,
  input  logic [LANES*BYTE_W-1:0] srcLo,
  output logic                    outValid,
  output logic [LANES*BYTE_W-1:0] result
);
  bpuStrobe_t strobes;

  bpu_ctrl ctrl_i (
    .inValid    (inValid),
    .opSel      (opSel),
    .narrowMode (narrowMode),
    .strobes    (strobes)
  );

  bpu_datapath #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W),
    .IMM_W  (IMM_W)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .srcHi    (srcHi),
    .srcLo    (srcLo),
    .imm      (imm),
    .outValid (outValid),
    .result   (result)
  );
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         opSel,
  input logic         narrowMode,
  input logic [7:0]   imm,
  input logic [127:0] srcHi,
  input logic [127:0] srcLo,
  input logic         outValid,
  input logic [127:0] result
);
  AST_ALIGN_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opSel && !narrowMode && imm == 8'd0) |=> (result == $past(srcLo))); // R1
  AST_ALIGN_ONE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opSel && !narrowMode && imm == 8'd16) |=> (result == $past(srcHi))); // R1
  AST_ALIGN_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (inValid && !opSel && imm >= (narrowMode ? 8'd16 : 8'd32)) |=> (result == '0)); // R2
  AST_SHUF_ZERO_BYTE: assert property (@(posedge clk) disable iff (rst)
    (inValid && opSel && srcLo[7]) |=> (result[7:0] == 8'h00)); // R4
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inValid && narrowMode) |=> (result[127:64] == '0)); // R6
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0)); // R9
endmodule

bind byte_perm_unit bpu_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .opSel      (opSel),
  .narrowMode (narrowMode),
  .imm        (imm),
  .srcHi      (srcHi),
  .srcLo      (srcLo),
  .outValid   (outValid),
  .result     (result)
);

// File: tb/byte_perm_unit_tb_top.sv
module byte_perm_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         opSel = 1'b0;
  logic         narrowMode = 1'b0;
  logic [7:0]   imm = '0;
  logic [127:0] srcHi = '0;
  logic [127:0] srcLo = '0;
  logic         outValid;
  logic [127:0] result;

  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_perm_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .narrowMode(narrowMode), .imm(imm), .srcHi(srcHi), .srcLo(srcLo),
    .outValid(outValid), .result(result)
  );

  function automatic logic [127:0] modelAlign(logic [127:0] a, logic [127:0] b,
                                              logic [7:0] n, logic nar);
    logic [7:0] joined [32];
    logic [127:0] r = '0;
    int w = nar ? 8 : 16;
    for (int k = 0; k < 32; k++) joined[k] = 8'h00;
    for (int k = 0; k < w; k++) begin
      joined[k]     = b[k*8 +: 8];
      joined[w + k] = a[k*8 +: 8];
    end
    for (int i = 0; i < w; i++)
      if (i + int'(n) < 2*w) r[i*8 +: 8] = joined[i + int'(n)];
    return r;
  endfunction

  function automatic logic [127:0] modelShuffle(logic [127:0] a, logic [127:0] b, logic nar);
    logic [127:0] r = '0;
    int w = nar ? 8 : 16;
    for (int i = 0; i < w; i++) begin
      logic [7:0] c = b[i*8 +: 8];
      int sel = nar ? int'(c[2:0]) : int'(c[3:0]);
      if (!c[7]) r[i*8 +: 8] = a[sel*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Drive on a falling edge; read on the next falling edge (after one capture edge).
  task automatic runOp(string tag, logic op, logic nar, logic [7:0] n,
                       logic [127:0] a, logic [127:0] b);
    logic [127:0] exp;
    @(negedge clk);
    inValid = 1'b1; opSel = op; narrowMode = nar; imm = n; srcHi = a; srcLo = b;
    exp = op ? modelShuffle(a, b, nar) : modelAlign(a, b, n, nar);
    @(negedge clk);
    check({tag, " result"}, result, exp);
    check("R8 valid after request", {127'd0, outValid}, 128'd1);
    inValid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [127:0] a, b, held, first;
    void'($urandom(32'd20240611));
    a = 128'hF0E0D0C0B0A090807060504030201000;
    b = 128'h0F0E0D0C0B0A09080706050403020100;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset outValid", {127'd0, outValid}, 128'd0);
    check("R9 reset result", result, '0);
    rst = 1'b0;

    // R1 / R2 wide align
    runOp("R1 align n0", 1'b0, 1'b0, 8'd0, a, b);
    runOp("R1 align n5", 1'b0, 1'b0, 8'd5, a, b);
    runOp("R1 align n15", 1'b0, 1'b0, 8'd15, a, b);
    runOp("R1 align n16", 1'b0, 1'b0, 8'd16, a, b);
    runOp("R2 align n17", 1'b0, 1'b0, 8'd17, a, b);
    runOp("R2 align n31", 1'b0, 1'b0, 8'd31, a, b);
    runOp("R2 align n32", 1'b0, 1'b0, 8'd32, a, b);
    runOp("R2 align n255", 1'b0, 1'b0, 8'd255, a, b);
    // R6 narrow align
    runOp("R6 narrow align n3", 1'b0, 1'b1, 8'd3, a, b);
    runOp("R6 narrow align n8", 1'b0, 1'b1, 8'd8, a, b);
    runOp("R2 narrow align n15", 1'b0, 1'b1, 8'd15, a, b);
    runOp("R2 narrow align n16", 1'b0, 1'b1, 8'd16, a, b);

    // R3 reverse shuffle, R4 zeroing
    runOp("R3 shuffle reverse", 1'b1, 1'b0, 8'd0, a, 128'h000102030405060708090A0B0C0D0E0F);
    runOp("R4 shuffle zero", 1'b1, 1'b0, 8'd0, a, 128'h80FF00FF8001800F8090A0B0C0D0E0FF);
    // R5: bits [6:4] ignored
    runOp("R5 shuffle base", 1'b1, 1'b0, 8'd0, a, 128'h0A0B0C0D01020304050607080E0F0009);
    first = result;
    runOp("R5 shuffle reserved set", 1'b1, 1'b0, 8'd0, a, 128'h7A3B5C6D11223344556677081E2F3049);
    check("R5 reserved bits no effect", result, first);
    // R7 narrow shuffle ignores bit 3
    runOp("R7 narrow shuffle", 1'b1, 1'b1, 8'd0, a, 128'hFFFFFFFFFFFFFFFF0F0E0D0C0B0A0908);
    check("R7 bit3 ignored", result, modelShuffle(a, 128'h0706050403020100, 1'b1));

    // R8 hold while idle
    held = result;
    @(negedge clk);
    srcHi = rnd128(); srcLo = rnd128(); opSel = 1'b0; imm = 8'd3;
    @(negedge clk);
    check("R8 hold result", result, held);
    check("R8 idle valid low", {127'd0, outValid}, 128'd0);

    // Random mix
    for (int t = 0; t < 400; t++) begin
      logic op  = 1'($urandom);
      logic nar = ($urandom % 4) == 0;
      logic [7:0] n = 8'($urandom % 40);
      runOp(op ? (nar ? "R7 rand narrow shuffle" : "R3 rand shuffle")
               : (nar ? "R6 rand narrow align" : "R1 rand align"),
            op, nar, n, rnd128(), rnd128());
    end

    // R9 reset mid-run
    runOp("R1 pre-reset", 1'b0, 1'b0, 8'd1, a, b);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset outValid", {127'd0, outValid}, 128'd0);
    check("R9 mid reset result", result, '0);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule